// File: doc/BRIEF.md
# Background Debug Serial Port

This block is the target end of a synchronous, full-duplex background-debug link. A host toggles a debug clock line and drives a serial data-in line. The block returns serial data on a data-out line. Every signal inside the block runs on the processor clock. The debug clock is never used as a clock: it passes through a synchronizer, and each rising edge it shows in the synchronized copy counts as one bit exchange.

A packet is 17 bits in each direction, most significant bit first. Bit 16 is a status flag and bits 15..0 are a data word. After the seventeenth exchange, the received packet is presented on a parallel output with a one-cycle valid strobe. The outgoing packet comes from a response register that the surrounding logic fills through a parallel word and strobe. When no response is waiting, or the port is still inside its recovery window after the previous packet, the block sends the not-ready code: flag 1 with data 0x0000.

The recognized response codes are:
- flag 0 with any data: valid data.
- flag 0 with 0xFFFF: accepted.
- flag 1 with 0x0001: bus fault.
- flag 1 with 0xFFFF: illegal request.

The block forwards any response word unchanged.

Top module: `bdm_serial_port`

## Requirements
- R1: A synchronous active-high `rst` drives `dbg_dout_o` low, keeps `rx_valid_o` low, empties the response register and clears the recovery window. It also restarts bit counting, so the first rising edge after reset is bit 16 of a new packet, even if reset arrived in the middle of a packet.
- R2: One bit is taken for each low-to-high transition of the synchronized debug clock. A debug clock held high for any number of cycles yields exactly one bit. The line must be seen low on at least one processor clock edge before the next bit.
- R3: If the processor-clock edge E0 is the first to sample the debug clock high, the data-in value sampled at E0 and E1 is shifted in at E2. `dbg_dout_o` changes only at E3. It holds its previous value up to that edge.
- R4: Incoming bits fill a 17-bit word most significant bit first. At the E2 edge of the seventeenth bit, `rx_word_o` takes the whole packet and `rx_valid_o` is high for exactly one cycle.
- R5: The outgoing packet is shifted out most significant bit first. Bit 16 (the status flag) appears on `dbg_dout_o` during the first exchange, and bit 0 appears during the seventeenth.
- R6: A word strobed in with `rsp_valid_i` is stored. It becomes the outgoing packet of the next packet that starts outside the recovery window, and is then used up.
- R7: If no response is stored when a packet starts, the outgoing packet is the not-ready code 0x10000 (flag 1, data 0x0000).
- R8: A packet that starts within GUARD_CYC (32) processor clocks of the previous packet's last bit sends the not-ready code. A stored response stays stored for a later packet.
- R9: A response strobed in while a packet is in flight does not change that packet's outgoing bits. It is sent in the next packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_clk_i | input | 1 | Debug clock from the host, asynchronous, sampled as an enable |
| dbg_din_i | input | 1 | Serial data from the host, asynchronous |
| dbg_dout_o | output | 1 | Serial data to the host, registered |
| rsp_word_i | input | DATA_W+1 | Next outgoing packet: status flag in the top bit, data below it |
| rsp_valid_i | input | 1 | Strobe that stores `rsp_word_i` |
| rx_word_o | output | DATA_W+1 | Last complete incoming packet |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_word_o` is updated |

## Verification
The bench samples `dbg_dout_o` one edge before and one edge after the expected fourth-cycle update of every bit. A design with an extra or missing pipeline register therefore shows the wrong value at one of the two points. One bit is held high for many cycles, so a level-sensitive design that counts every high cycle would lose framing and return a wrong received word. Responses are strobed in right after a packet and in the middle of one. This catches a design that ignores the recovery window, drops the stored response when that window refuses it, or loads a response into a packet already in flight. A reset in the middle of a packet shows whether the bit counter restarts, and random host words and response words mixed with empty-register packets cover the data path.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

  // Number of data bits in one packet when no parameter overrides it.
  localparam int BDM_DATA_W = 16;

  // Processor clocks after a packet during which new packets get not-ready.
  localparam int BDM_GUARD_CYC = 32;

  // Value of the status flag: clear for valid or accepted, set for the
  // not-ready, fault and illegal codes.
  typedef enum logic {
    STAT_CLEAR = 1'b0,
    STAT_FLAG  = 1'b1
  } bdm_stat_e;

  // Width of a counter that must hold the values 0..n.
  function automatic int bdm_ctr_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Bit index that follows idx in a packet of pkt_w bits; wraps to 0 at the end.
  function automatic int bdm_next_idx(input int idx, input int pkt_w);
    return (idx == pkt_w - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/bdm_in_sync.sv
module bdm_in_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg1_q;
  logic [WIDTH-1:0] stg2_q;

  // Each input gets its own two-register chain.
  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) begin
        stg1_q[g] <= 1'b0;
        stg2_q[g] <= 1'b0;
      end else begin
        stg1_q[g] <= async_i[g];
        stg2_q[g] <= stg1_q[g];
      end
    end
  end

  assign sync_o = stg2_q;

endmodule

// File: rtl/bdm_rx_frame.sv
module bdm_rx_frame
  import bdm_pkg::*;
#(
  parameter int DATA_W = BDM_DATA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dclk_sync_i,
  input  logic            din_sync_i,
  output logic            step_o,
  output logic            first_o,
  output logic            last_o,
  output logic [DATA_W:0] rx_word_o,
  output logic            rx_valid_o
);

  localparam int PKT_W = DATA_W + 1;
  localparam int CNT_W = bdm_ctr_w(PKT_W - 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_W - 1);

  logic             dclk_dly_q;
  logic [CNT_W-1:0] idx_q;
  logic [PKT_W-1:0] sh_q;
  logic [PKT_W-1:0] sh_next;

  // A bit is taken when the synchronized debug clock goes from low to high.
  assign step_o  = dclk_sync_i & ~dclk_dly_q;
  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == LAST_IDX);
  assign sh_next = {sh_q[PKT_W-2:0], din_sync_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_dly_q <= 1'b0;
      idx_q      <= '0;
      sh_q       <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      dclk_dly_q <= dclk_sync_i;
      rx_valid_o <= 1'b0;
      if (step_o) begin
        sh_q  <= sh_next;
        idx_q <= CNT_W'(bdm_next_idx(int'(idx_q), PKT_W));
        if (last_o) begin
          rx_word_o  <= sh_next;
          rx_valid_o <= 1'b1;
        end
      end
    end
  end

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R4

  AST_RX_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(step_o && last_o)); // R4

  AST_STEP_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o); // R2

endmodule

// File: rtl/bdm_tx_path.sv
module bdm_tx_path
  import bdm_pkg::*;
#(
  parameter int DATA_W    = BDM_DATA_W,
  parameter int GUARD_CYC = BDM_GUARD_CYC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic            first_i,
  input  logic            last_i,
  input  logic [DATA_W:0] rsp_word_i,
  input  logic            rsp_valid_i,
  output logic            dout_o
);

  localparam int PKT_W = DATA_W + 1;
  localparam int GRD_W = bdm_ctr_w(GUARD_CYC);
  localparam logic [PKT_W-1:0] NOT_READY = {STAT_FLAG, {DATA_W{1'b0}}};

  logic             pend_q;
  logic [PKT_W-1:0] pend_word_q;
  logic [GRD_W-1:0] guard_q;
  logic             guard_busy;
  logic             take_rsp;
  logic [PKT_W-1:0] load_word;
  logic [PKT_W-1:0] tx_sh_q;
  logic             tx_bit_q;
  logic             dout_q;

  assign guard_busy = (guard_q != '0);
  assign take_rsp   = step_i & first_i & pend_q & ~guard_busy;
  assign load_word  = take_rsp ? pend_word_q : NOT_READY;
  assign dout_o     = dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_word_q <= '0;
      guard_q     <= '0;
      tx_sh_q     <= '0;
      tx_bit_q    <= 1'b0;
      dout_q      <= 1'b0;
    end else begin
      // The bit for this exchange is chosen on the step edge.
      if (step_i) begin
        if (first_i) begin
          tx_bit_q <= load_word[PKT_W-1];
          tx_sh_q  <= {load_word[PKT_W-2:0], 1'b0};
        end else begin
          tx_bit_q <= tx_sh_q[PKT_W-1];
          tx_sh_q  <= {tx_sh_q[PKT_W-2:0], 1'b0};
        end
      end
      // A new strobe wins over the response being used up in the same cycle.
      if (rsp_valid_i) begin
        pend_q      <= 1'b1;
        pend_word_q <= rsp_word_i;
      end else if (take_rsp) begin
        pend_q <= 1'b0;
      end
      if (step_i && last_i) begin
        guard_q <= GRD_W'(GUARD_CYC);
      end else if (guard_busy) begin
        guard_q <= guard_q - 1'b1;
      end
      // The output register updates one edge after the step edge.
      dout_q <= tx_bit_q;
    end
  end

  AST_DOUT_IN_RESET: assert property (@(posedge clk)
    rst |=> !dout_o); // R1

  AST_DOUT_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout_o) |-> $past(step_i, 2)); // R3

  AST_EMPTY_SENDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (step_i && first_i && !pend_q) |=> tx_bit_q); // R7

  AST_GUARD_SENDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (step_i && first_i && guard_busy) |=> tx_bit_q); // R8

  AST_GUARD_KEEPS_RSP: assert property (@(posedge clk) disable iff (rst)
    (step_i && first_i && guard_busy && pend_q) |=> pend_q); // R8

endmodule

// File: rtl/bdm_serial_port.sv
module bdm_serial_port
  import bdm_pkg::*;
#(
  parameter int DATA_W    = BDM_DATA_W,
  parameter int GUARD_CYC = BDM_GUARD_CYC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dbg_clk_i,
  input  logic            dbg_din_i,
  output logic            dbg_dout_o,
  input  logic [DATA_W:0] rsp_word_i,
  input  logic            rsp_valid_i,
  output logic [DATA_W:0] rx_word_o,
  output logic            rx_valid_o
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] synced;
  logic              bit_step;
  logic              bit_first;
  logic              bit_last;

  assign raw_in = {dbg_clk_i, dbg_din_i};

  bdm_in_sync #(
    .WIDTH (SYNC_W)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_in),
    .sync_o  (synced)
  );

  bdm_rx_frame #(
    .DATA_W (DATA_W)
  ) u_rx (
    .clk         (clk),
    .rst         (rst),
    .dclk_sync_i (synced[1]),
    .din_sync_i  (synced[0]),
    .step_o      (bit_step),
    .first_o     (bit_first),
    .last_o      (bit_last),
    .rx_word_o   (rx_word_o),
    .rx_valid_o  (rx_valid_o)
  );

  bdm_tx_path #(
    .DATA_W    (DATA_W),
    .GUARD_CYC (GUARD_CYC)
  ) u_tx (
    .clk         (clk),
    .rst         (rst),
    .step_i      (bit_step),
    .first_i     (bit_first),
    .last_i      (bit_last),
    .rsp_word_i  (rsp_word_i),
    .rsp_valid_i (rsp_valid_i),
    .dout_o      (dbg_dout_o)
  );

  AST_STROBE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(bit_step)); // R4

endmodule

// File: tb/bdm_serial_port_tb_top.sv
module bdm_serial_port_tb_top;

  localparam logic [16:0] NRDY = 17'h10000;
  localparam logic [16:0] OK   = 17'h0FFFF;
  localparam logic [16:0] BERR = 17'h10001;
  localparam logic [16:0] ILL  = 17'h1FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_clk = 1'b0;
  logic        dbg_din = 1'b0;
  logic        dbg_dout;
  logic [16:0] rsp_word = '0;
  logic        rsp_valid = 1'b0;
  logic [16:0] rx_word;
  logic        rx_valid;

  int errors = 0;
  int checks = 0;
  int rx_count = 0;
  logic [16:0] rx_cap = '0;
  logic prev_dout = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bdm_serial_port dut_i (
    .clk         (clk),
    .rst         (rst),
    .dbg_clk_i   (dbg_clk),
    .dbg_din_i   (dbg_din),
    .dbg_dout_o  (dbg_dout),
    .rsp_word_i  (rsp_word),
    .rsp_valid_i (rsp_valid),
    .rx_word_o   (rx_word),
    .rx_valid_o  (rx_valid)
  );

  // Watches the receive strobe; a strobe held for two cycles counts twice.
  always @(negedge clk) begin
    if (rx_valid) begin
      rx_count++;
      rx_cap = rx_word;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One exchange: the debug clock is high for `hold` cycles, then low for 2.
  // Before the 4th edge the old output value must still be present (R3).
  task automatic send_bit(input logic din, input int hold, output logic got);
    logic pre;
    @(negedge clk);
    dbg_din = din;
    dbg_clk = 1'b1;
    repeat (3) @(negedge clk);
    pre = dbg_dout;
    @(negedge clk);
    got = dbg_dout;
    if (got != prev_dout)
      check(pre == prev_dout, "R3 output changed before 4th edge", {31'd0, pre}, {31'd0, prev_dout});
    prev_dout = got;
    repeat (hold - 4) @(negedge clk);
    dbg_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Expected model (R5): bits leave most significant first, bit 16 first.
  function automatic logic [16:0] assemble(input logic [16:0] bits);
    return bits;
  endfunction

  task automatic run_packet(input logic [16:0] host, input logic [16:0] exp_rsp,
                            input int long_idx, input string tag);
    logic [16:0] got_rsp;
    logic b;
    int cnt0;
    cnt0 = rx_count;
    for (int i = 16; i >= 0; i--) begin
      send_bit(host[i], (i == long_idx) ? 20 : 4, b);
      got_rsp[i] = b;
    end
    check(assemble(got_rsp) == exp_rsp, {tag, " R5 outgoing packet"}, {15'd0, got_rsp}, {15'd0, exp_rsp});
    check(rx_count == cnt0 + 1, "R4 single strobe per packet", rx_count - cnt0, 1);
    check(rx_cap == host, "R4 received word", {15'd0, rx_cap}, {15'd0, host});
  endtask

  task automatic give_rsp(input logic [16:0] w);
    @(negedge clk);
    rsp_word = w;
    rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic b;
    int c0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(dbg_dout == 1'b0, "R1 dout after reset", {31'd0, dbg_dout}, 0);
    check(rx_valid == 1'b0, "R1 rx_valid after reset", {31'd0, rx_valid}, 0);

    // R7: nothing stored
    run_packet(17'h1A5C3, NRDY, -1, "R7 empty");
    repeat (40) @(negedge clk);

    // R6: stored response is sent, then used up
    give_rsp(OK);
    repeat (40) @(negedge clk);
    run_packet(17'h0F00F, OK, -1, "R6 stored");
    repeat (40) @(negedge clk);
    run_packet(17'h00001, NRDY, -1, "R6 used up");

    // R8: packet right after a packet gets not-ready, stored word survives
    give_rsp(BERR);
    run_packet(17'h15555, NRDY, -1, "R8 inside window");
    repeat (40) @(negedge clk);
    run_packet(17'h0AAAA, BERR, -1, "R8 kept for later");
    repeat (40) @(negedge clk);

    // R9: strobe during a packet does not affect it
    fork
      run_packet(17'h13579, NRDY, -1, "R9 in flight");
      begin
        repeat (30) @(negedge clk);
        give_rsp(ILL);
      end
    join
    repeat (40) @(negedge clk);
    run_packet(17'h02468, ILL, -1, "R9 next packet");
    repeat (40) @(negedge clk);

    // R2: one bit held high for many cycles is one bit
    give_rsp(17'h0BEEF);
    repeat (40) @(negedge clk);
    run_packet(17'h1C0DE, 17'h0BEEF, 8, "R2 long high");
    repeat (40) @(negedge clk);

    // R1: reset in the middle of a packet restarts the bit count
    for (int i = 0; i < 5; i++) send_bit(1'b1, 4, b);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dbg_dout == 1'b0, "R1 dout during reset", {31'd0, dbg_dout}, 0);
    rst = 1'b0;
    prev_dout = 1'b0;
    c0 = rx_count;
    repeat (2) @(negedge clk);
    check(rx_count == c0, "R1 no strobe after reset", rx_count - c0, 0);
    run_packet(17'h0123F, NRDY, -1, "R1 after mid reset");
    repeat (40) @(negedge clk);

    // Random packets with and without stored responses (R4 R5 R6 R7)
    for (int k = 0; k < 10; k++) begin
      logic [16:0] hw;
      logic [16:0] rw;
      logic [16:0] exp;
      bit load;
      hw = 17'($urandom);
      rw = 17'($urandom);
      load = 1'($urandom);
      if (load) give_rsp(rw);
      exp = load ? rw : NRDY;
      repeat (40 + int'($urandom % 40)) @(negedge clk);
      run_packet(hw, exp, -1, load ? "R6 random" : "R7 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule